// File: doc/BRIEF.md
# Guard-Limited Single-Precision Adder

This block adds two 32-bit single-precision floating-point operands. Before the add it can trim the operand with the smaller exponent. The trimming copies the result of a vector unit that carries only one guard bit, instead of the guard, round and sticky bits that a conforming adder keeps. It looks at the signed exponent gap (exponent of B minus exponent of A) and, depending on a 2-bit mode, does one of three things:

- leaves both operands alone;
- reduces a far-away operand to its sign bit;
- clears the low mantissa bits of the smaller operand that a one-guard-bit datapath would never see.

The trimmed pair then goes through an ordinary align, add, normalise and round-to-nearest-even datapath. The block is a two-stage pipeline that takes a new operand pair on every clock. The first stage registers the trimmed operands. The second stage registers the rounded sum. Denormal encodings are read and written as signed zero. Exponent field 255 is treated as an ordinary large exponent.

Top module: `guard_lim_fadd`

## Requirements
- R1: A pair sampled with `in_valid` high at a rising edge appears on `out_sum` with `out_valid` high exactly two rising edges later. Pairs may be sampled on consecutive edges. While `rst_n` is low at an edge, `out_valid` and `out_sum` are 0 after that edge.
- R2: In mode 0 the output is the single-precision sum of the operands, rounded to nearest with ties to even.
- R3: The exponent is bits 30:23 and the gap is exponent(B) minus exponent(A). When the gap is 0, no mode alters either operand.
- R4: In mode 1, a gap of +25 or more replaces A by its sign bit alone (A AND 0x80000000). A gap of -25 or less does the same to B.
- R5: In mode 1, a gap from -24 to +24 leaves both operands unaltered.
- R6: In mode 2, a gap from +1 to +24 clears the low (gap-1) bits of A.
- R7: In mode 2, a gap from -24 to -1 clears the low (-gap-1) bits of B.
- R8: In mode 2, a gap whose magnitude is 25 or more keeps only the sign bit of the operand with the smaller exponent, as in R4.
- R9: Mode 3 gives the same results as mode 0.
- R10: An operand whose exponent field is 0 counts as zero. A result whose biased exponent would be 0 or less is output as a zero carrying the result sign.
- R11: An exact cancellation gives +0 (0x00000000). The sum of two negative zeros gives 0x80000000.
- R12: Exponent field 255 is an ordinary exponent. A result whose exponent would exceed 255 saturates to the sign bit followed by 0x7F800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 32 | Operand A, single-precision encoding |
| in_b | input | 32 | Operand B, single-precision encoding |
| in_mode | input | 2 | 0 plain add, 1 coarse flush, 2 single guard, 3 plain add |
| out_valid | output | 1 | Sum present this cycle |
| out_sum | output | 32 | Rounded sum, single-precision encoding |

## Verification
Every sum is due exactly two rising edges after the edge that samples its operands. The result does not depend on the mode or on how far the operands must be aligned. The driver records each expected word, worked out by hand from the requirements, in issue order. The monitor reads the outputs on the falling edge, so a result registered at an edge is checked half a period later. Because the driver issues pairs back to back and also with idle gaps, any change in latency, or any dropped or extra valid, shows up as a result out of order or a result that arrives with no expected word waiting.

// File: rtl/gfa_pkg.sv
// Package: shared widths and the mode encoding for the guard-limited adder.
// Assumes the single-precision layout: sign, 8-bit exponent, 23-bit fraction.
package gfa_pkg;
    localparam int EXP_W      = 8;
    localparam int FRAC_W     = 23;
    localparam int WORD_W     = 1 + EXP_W + FRAC_W;
    localparam int MANT_W     = FRAC_W + 1;
    localparam int GRS_W      = 3;
    localparam int EXT_W      = MANT_W + GRS_W;
    localparam int GAP_W      = EXP_W + 2;
    localparam int FLUSH_DIST = MANT_W + 1;
    localparam int EXP_MAX    = (1 << EXP_W) - 1;

    typedef enum logic [1:0] {
        MODE_PLAIN   = 2'd0,
        MODE_COARSE  = 2'd1,
        MODE_GUARD1  = 2'd2,
        MODE_PLAIN_B = 2'd3
    } add_mode_e;
endpackage

// File: rtl/gfa_precond.sv
// Operand trimmer: computes exponent(B) - exponent(A) and, per mode, either
// flushes the far operand to its sign or clears the low bits of the smaller
// operand that a one-guard-bit datapath drops. Purely combinational.
module gfa_precond
    import gfa_pkg::*;
(
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [1:0]        mode,
    output logic [WORD_W-1:0] trim_a,
    output logic [WORD_W-1:0] trim_b
);
    localparam logic signed [GAP_W-1:0] FAR_POS   = GAP_W'(FLUSH_DIST);
    localparam logic signed [GAP_W-1:0] FAR_NEG   = -FAR_POS;
    localparam logic [WORD_W-1:0]       SIGN_ONLY = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0]       ALL_ONES  = '1;

    logic signed [GAP_W-1:0] gap;
    logic [4:0]              sh_pos;
    logic [4:0]              sh_neg;
    logic                    use_coarse;
    logic                    use_guard;

    // Signed exponent gap and the shift counts for the single-guard masks.
    always_comb begin
        gap    = $signed({2'b00, op_b[WORD_W-2 -: EXP_W]}) - $signed({2'b00, op_a[WORD_W-2 -: EXP_W]});
        sh_pos = 5'(gap - GAP_W'(1));
        sh_neg = 5'(-gap - GAP_W'(1));
    end

    // Decode which trimming rule the mode selects.
    always_comb begin
        use_guard  = (mode == MODE_GUARD1);
        use_coarse = (mode == MODE_COARSE) || use_guard;
    end

    // Apply the far-flush rule first, then the single-guard bit clearing.
    always_comb begin
        trim_a = op_a;
        trim_b = op_b;
        if (use_coarse && gap >= FAR_POS) begin
            trim_a = op_a & SIGN_ONLY;
        end else if (use_coarse && gap <= FAR_NEG) begin
            trim_b = op_b & SIGN_ONLY;
        end else if (use_guard && gap > 0) begin
            trim_a = op_a & (ALL_ONES << sh_pos);
        end else if (use_guard && gap < 0) begin
            trim_b = op_b & (ALL_ONES << sh_neg);
        end
    end
endmodule

// File: rtl/gfa_add_core.sv
// Single-precision add datapath: orders the operands by magnitude, aligns
// with guard/round/sticky, adds or subtracts, normalises and rounds to
// nearest-even. Denormals read and write as signed zero; exponent 255 is
// ordinary and overflow saturates. Purely combinational.
module gfa_add_core
    import gfa_pkg::*;
(
    input  logic [WORD_W-1:0] x,
    input  logic [WORD_W-1:0] y,
    output logic [WORD_W-1:0] sum
);
    localparam int                      SH_W   = 6;
    localparam logic [SH_W-1:0]         SH_CAP = SH_W'(EXT_W);
    localparam logic signed [GAP_W:0]   E_TOP  = (GAP_W+1)'(EXP_MAX);

    logic [WORD_W-2:0] mag_x, mag_y;
    logic [WORD_W-1:0] big, sml;
    logic [EXP_W-1:0]  e_big, e_sml, e_gap;
    logic [MANT_W-1:0] m_big, m_sml;
    logic [SH_W-1:0]   shamt;
    logic [2*EXT_W-1:0] wide;
    logic [EXT_W-1:0]  ext_big, ext_sml;
    logic              eff_sub;
    logic [EXT_W:0]    raw;
    logic [EXT_W-1:0]  norm;
    logic [4:0]        lz;
    logic              found;
    logic signed [GAP_W:0] e_norm, e_fin;
    logic              rnd_up;
    logic [MANT_W:0]   mant_r;
    logic [FRAC_W-1:0] frac;
    logic              sgn;

    // Magnitudes with denormals forced to zero, then order the operands.
    always_comb begin
        mag_x = (x[WORD_W-2 -: EXP_W] == '0) ? '0 : x[WORD_W-2:0];
        mag_y = (y[WORD_W-2 -: EXP_W] == '0) ? '0 : y[WORD_W-2:0];
        big   = (mag_y > mag_x) ? y : x;
        sml   = (mag_y > mag_x) ? x : y;
        e_big = big[WORD_W-2 -: EXP_W];
        e_sml = sml[WORD_W-2 -: EXP_W];
        m_big = (e_big == '0) ? '0 : {1'b1, big[FRAC_W-1:0]};
        m_sml = (e_sml == '0) ? '0 : {1'b1, sml[FRAC_W-1:0]};
    end

    // Align the smaller mantissa, folding every lost bit into sticky.
    always_comb begin
        e_gap   = e_big - e_sml;
        shamt   = ({1'b0, e_gap} > {1'b0, SH_CAP}) ? SH_CAP : SH_W'(e_gap);
        ext_big = {m_big, {GRS_W{1'b0}}};
        wide    = {m_sml, {GRS_W{1'b0}}, {EXT_W{1'b0}}} >> shamt;
        ext_sml = wide[2*EXT_W-1 -: EXT_W];
        ext_sml[0] = ext_sml[0] | (|wide[EXT_W-1:0]);
        eff_sub = big[WORD_W-1] ^ sml[WORD_W-1];
        raw     = eff_sub ? ({1'b0, ext_big} - {1'b0, ext_sml})
                          : ({1'b0, ext_big} + {1'b0, ext_sml});
    end

    // Leading-zero count over the non-carry part of the raw sum.
    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = EXT_W-1; i >= 0; i--) begin
            if (!found && raw[i]) begin
                lz    = 5'(EXT_W-1-i);
                found = 1'b1;
            end
        end
    end

    // Normalise: shift right on carry-out, else left by the zero count.
    always_comb begin
        if (raw[EXT_W]) begin
            norm   = {raw[EXT_W:2], raw[1] | raw[0]};
            e_norm = $signed({3'b000, e_big}) + (GAP_W+1)'(1);
        end else begin
            norm   = raw[EXT_W-1:0] << lz;
            e_norm = $signed({3'b000, e_big}) - $signed({6'b0, lz});
        end
    end

    // Round to nearest-even and re-normalise on mantissa carry.
    always_comb begin
        rnd_up = norm[2] & (norm[1] | norm[0] | norm[3]);
        mant_r = {1'b0, norm[EXT_W-1:GRS_W]} + (MANT_W+1)'(rnd_up);
        if (mant_r[MANT_W]) begin
            e_fin = e_norm + (GAP_W+1)'(1);
            frac  = mant_r[FRAC_W:1];
        end else begin
            e_fin = e_norm;
            frac  = mant_r[FRAC_W-1:0];
        end
    end

    // Pack the result with the zero, underflow and overflow rules.
    always_comb begin
        sgn = big[WORD_W-1];
        if (raw == '0) begin
            sum = {big[WORD_W-1] & sml[WORD_W-1], {(WORD_W-1){1'b0}}};
        end else if (e_fin <= 0) begin
            sum = {sgn, {(WORD_W-1){1'b0}}};
        end else if (e_fin > E_TOP) begin
            sum = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            sum = {sgn, e_fin[EXP_W-1:0], frac};
        end
    end
endmodule

// File: rtl/guard_lim_fadd.sv
// Top: two-stage guard-limited adder. Stage 1 registers the trimmed
// operands, stage 2 registers the rounded sum. Accepts one pair per cycle.
// Synchronous active-low reset clears both stages.
module guard_lim_fadd
    import gfa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_sum
);
    logic [WORD_W-1:0] trim_a, trim_b;
    logic [WORD_W-1:0] s1_a, s1_b;
    logic              s1_v;
    logic [WORD_W-1:0] core_sum;

    gfa_precond u_precond (
        .op_a   (in_a),
        .op_b   (in_b),
        .mode   (in_mode),
        .trim_a (trim_a),
        .trim_b (trim_b)
    );

    // Stage 1: hold the trimmed operand pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s1_a <= '0;
            s1_b <= '0;
        end else begin
            s1_v <= in_valid;
            s1_a <= trim_a;
            s1_b <= trim_b;
        end
    end

    gfa_add_core u_core (
        .x   (s1_a),
        .y   (s1_b),
        .sum (core_sum)
    );

    // Stage 2: hold the rounded sum and its valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= s1_v;
            out_sum   <= core_sum;
        end
    end
endmodule

// File: rtl/gfa_chk.sv
// Checker: timing and corner-case properties of guard_lim_fadd, bound to
// every instance of the top module.
module gfa_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_a,
    input logic [31:0] in_b,
    input logic [1:0]  in_mode,
    input logic        out_valid,
    input logic [31:0] out_sum
);
    // R1: every accepted pair yields a valid two edges later.
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R1: no valid appears without a pair two edges earlier.
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R1: reset clears the output valid.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R11: exact opposites cancel to positive zero.
    a_r11_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_a[30:23] != 8'd0 && in_a == (in_b ^ 32'h8000_0000))
        |-> ##2 out_sum == 32'h0000_0000);

    // R11: negative zero plus negative zero keeps the sign.
    a_r11_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_a == 32'h8000_0000 && in_b == 32'h8000_0000)
        |-> ##2 out_sum == 32'h8000_0000);

    // R10: two denormal or zero inputs give a zero magnitude.
    a_r10_denorm_in: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_a[30:23] == 8'd0 && in_b[30:23] == 8'd0)
        |-> ##2 out_sum[30:0] == 31'd0);

    // R4: coarse mode with A far below B returns B unchanged.
    a_r4_far_a: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd1 && {1'b0, in_b[30:23]} >= {1'b0, in_a[30:23]} + 9'd25)
        |-> ##2 out_sum == $past(in_b, 2));

    // R8: single-guard mode with B far below A returns A unchanged.
    a_r8_far_b: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd2 && {1'b0, in_a[30:23]} >= {1'b0, in_b[30:23]} + 9'd25)
        |-> ##2 out_sum == $past(in_a, 2));
endmodule

bind guard_lim_fadd gfa_chk u_gfa_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/guard_lim_fadd_tb.sv
// Scoreboard bench: the driver queues hand-worked expected sums, the
// monitor compares them in order on the falling edge.
module guard_lim_fadd_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [31:0] out_sum;

    typedef struct {
        logic [31:0] want;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    guard_lim_fadd u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_mode   (in_mode),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    // Drive one pair at the falling edge and queue its expected sum.
    task automatic send(input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] m, input logic [31:0] want,
                        input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_a     = a;
        in_b     = b;
        in_mode  = m;
        sb_q.push_back('{want, tag});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_a     = 32'hDEAD_BEEF;
            in_b     = 32'h1234_5678;
        end
    endtask

    // Monitor: pop and compare each result as it appears.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            vectors++;
            if (sb_q.size() == 0) begin
                misses++;
                $display("FAIL R1 unexpected valid: actual %08h expected none", out_sum);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                if (out_sum !== it.want) begin
                    misses++;
                    $display("FAIL %s: actual %08h expected %08h", it.tag, out_sum, it.want);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finished, %0d results pending", sb_q.size());
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        if (out_valid !== 1'b0 || out_sum !== 32'h0) begin
            misses++;
            $display("FAIL R1 reset: actual %b/%08h expected 0/00000000", out_sum, out_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: plain add, back to back
        send(32'h4B1E_D4A7, 32'h43A0_2666, 2'd0, 32'h4B1E_D5E7, "R2 test vector");
        send(32'h4B1E_D4A8, 32'h43A0_2666, 2'd0, 32'h4B1E_D5E8, "R2 neighbour");
        send(32'h3F80_0000, 32'h3F80_0000, 2'd0, 32'h4000_0000, "R2 carry out");
        send(32'h3FC0_0000, 32'hBF00_0000, 2'd0, 32'h3F80_0000, "R2 subtract");
        send(32'h3F80_0000, 32'h3380_0000, 2'd0, 32'h3F80_0000, "R2 tie to even down");
        send(32'h3F80_0001, 32'h3380_0000, 2'd0, 32'h3F80_0002, "R2 tie to even up");
        send(32'hBFC0_0000, 32'h4C00_0000, 2'd0, 32'h4BFF_FFFF, "R2 far subtract");
        idle(2);
        // R4 / R5: coarse flush
        send(32'hBFC0_0000, 32'h4C00_0000, 2'd1, 32'h4C00_0000, "R4 gap +25 flush A");
        send(32'h4C00_0000, 32'hBFC0_0000, 2'd1, 32'h4C00_0000, "R4 gap -25 flush B");
        send(32'hBFC0_0000, 32'h4B80_0000, 2'd1, 32'h4B7F_FFFE, "R5 gap +24 untouched");
        idle(1);
        // R3 / R6 / R7 / R8: single guard
        send(32'h3FC0_0000, 32'h3F80_0000, 2'd2, 32'h4020_0000, "R3 gap 0 untouched");
        send(32'hBFC0_0000, 32'h4B80_0000, 2'd2, 32'h4B7F_FFFF, "R6 gap +24 clears A");
        send(32'h4B80_0000, 32'hBFC0_0000, 2'd2, 32'h4B7F_FFFF, "R7 gap -24 clears B");
        send(32'h4B1E_D4A7, 32'h43A0_2666, 2'd2, 32'h4B1E_D5E7, "R7 gap -15 test vector");
        send(32'hBFC0_0000, 32'h4C00_0000, 2'd2, 32'h4C00_0000, "R8 gap +25 flush A");
        // R9: mode 3 equals mode 0
        send(32'hBFC0_0000, 32'h4B80_0000, 2'd3, 32'h4B7F_FFFE, "R9 mode 3 plain");
        send(32'hBFC0_0000, 32'h4C00_0000, 2'd3, 32'h4BFF_FFFF, "R9 mode 3 far");
        // R10: denormal handling
        send(32'h0040_0000, 32'h0080_0000, 2'd0, 32'h0080_0000, "R10 denormal input");
        send(32'h00C0_0000, 32'h8080_0000, 2'd0, 32'h0000_0000, "R10 underflow flush");
        // R11: zero signs
        send(32'h3F80_0000, 32'hBF80_0000, 2'd0, 32'h0000_0000, "R11 cancel");
        send(32'h8000_0000, 32'h8000_0000, 2'd0, 32'h8000_0000, "R11 neg zeros");
        send(32'h8000_0000, 32'h0000_0000, 2'd0, 32'h0000_0000, "R11 mixed zeros");
        // R12: exponent 255 ordinary, overflow saturates
        send(32'h7F00_0000, 32'h7F00_0000, 2'd0, 32'h7F80_0000, "R12 reach exp 255");
        send(32'hFF80_0000, 32'hFF80_0000, 2'd0, 32'hFF80_0000, "R12 saturate");
        idle(4);

        // R1: every queued result must have arrived
        vectors++;
        if (sb_q.size() != 0) begin
            misses++;
            $display("FAIL R1 missing results: actual %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule